// File: doc/BRIEF.md
# Power-Up and Test-Mode Controller

This block is the control logic of a clock generator with several output groups. It watches one shared control pin and a few strap pins, and it takes two test bits from the register file. From these it produces a 2-bit control code for every output group: run, high-impedance, drive-low or divided reference. The analog drivers and the synthesizers act on these codes.

Before the first power-good, the shared pin is an active-low power-good input. When it goes low for the first time, the frequency-select and test-select straps are sampled and then held. After that the same pin is an asynchronous active-high power-down. Outputs start running only after a startup delay, counted in reference-clock cycles. After a power-down ends, the single-ended groups resume as soon as the synchronized pin shows the release. The differential groups wait for a separate exit delay.

Test mode can be entered in two ways: by the sampled strap, or by a register bit. It is sticky and only a power-on reset clears it. When test mode is entered by strap, a real-time pin chooses the test output type. When it is entered by register, a second register bit chooses the type.

Top module: `clkpu_ctrl`

## Requirements
- R1: From power-on reset until the first power-good, the codes are fixed. Differential groups and strap-shared single-ended groups show high-impedance (code 1). Other single-ended groups show drive-low (code 2).
- R2: `fsel_latched` reads 1 until power-good is first seen low. On the third rising clock edge after that fall, it takes the value of `strap_fsel`. After that it ignores the strap, including across power-down cycles.
- R3: With no power-down, all groups show their live code on rising edge STARTUP_CYC+3 after power-good first falls, and not before. While they wait, differential groups show code 1 and single-ended groups show code 2.
- R4: After the first power-good, a high level on the shared pin forces the power-down codes at once, with no clock edge needed. Differential groups show code 1. All single-ended groups show code 2, including the strap-shared ones.
- R5: After the shared pin falls again, single-ended groups show their live code from the third rising edge. Differential groups keep code 1 until rising edge PDEXIT_CYC+3.
- R6: If test-select was sampled as 1, every live code is 3 (divided reference) while `test_pin` is 1, and 1 while it is 0. The code follows `test_pin` combinationally. The two register bits have no effect.
- R7: If test-select was sampled as 0, test mode starts one edge after `reg_test_en` is seen high. The live code is then 3 when `reg_test_type` is 1 and 1 when it is 0. `test_pin` has no effect.
- R8: Test mode stays on after `reg_test_en` is cleared and after a power-down cycle. Only `rst_n` clears it.
- R9: With test-select sampled as 0 and `reg_test_en` left at 0, the live code is run (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all delays are counted in its cycles |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwrgd_pd | input | 1 | Shared pin: active-low power-good until first seen low, then active-high power-down |
| strap_fsel | input | 1 | Frequency-select strap (1 = 100 MHz, 0 = 133 MHz) |
| strap_tsel | input | 1 | Test-select strap |
| test_pin | input | 1 | Real-time test type for strap test mode (1 = divided reference) |
| reg_test_en | input | 1 | Register bit that requests test mode |
| reg_test_type | input | 1 | Register bit for the test type in register test mode |
| grp_codes | output | 2*NGRP | Per-group code, group g at bits [2g+1:2g] |
| fsel_latched | output | 1 | Sampled frequency select, read-only register bit |

## Verification
The hardest situation to reach from the ports is test mode that has outlived both the register bit that started it and a complete power-down with its exit delay. The bench has to be in register test mode, clear the bit, raise and drop the shared pin, and then count edges through the split single-ended and differential release. To keep this short, the bench shrinks both delays through parameters. It changes the pin on falling edges and counts rising edges from that point, so each transition is checked on the exact edge where it is due and on the edge before.

// File: rtl/clkpu_pkg.sv
`timescale 1ns/1ps
package clkpu_pkg;

  typedef enum logic [1:0] {
    C_RUN    = 2'd0,
    C_HIZ    = 2'd1,
    C_LOW    = 2'd2,
    C_REFDIV = 2'd3
  } code_t;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_START = 3'd1,
    PH_RUN   = 3'd2,
    PH_PD    = 3'd3,
    PH_EXIT  = 3'd4
  } phase_t;

  // Counter width able to hold the larger delay minus one.
  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // Code a running group shows: normal run or the selected test output.
  function automatic code_t live_code(input logic test_on, input logic test_ref);
    if (!test_on) return C_RUN;
    return test_ref ? C_REFDIV : C_HIZ;
  endfunction

  // Full per-group decision.
  function automatic code_t group_code(input phase_t ph, input logic pd_force,
                                       input logic is_diff, input logic is_strap,
                                       input logic test_on, input logic test_ref);
    code_t lc;
    lc = live_code(test_on, test_ref);
    if (pd_force || ph == PH_PD) return is_diff ? C_HIZ : C_LOW;
    case (ph)
      PH_WAIT:  return (is_diff || is_strap) ? C_HIZ : C_LOW;
      PH_START: return is_diff ? C_HIZ : C_LOW;
      PH_EXIT:  return is_diff ? C_HIZ : lc;
      PH_RUN:   return lc;
      default:  return is_diff ? C_HIZ : C_LOW;
    endcase
  endfunction

endpackage

// File: rtl/clkpu_sync.sv
`timescale 1ns/1ps
module clkpu_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= RST_VAL;
        else        pipe_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/clkpu_seq.sv
`timescale 1ns/1ps
module clkpu_seq
  import clkpu_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 45000,
  parameter int unsigned PDEXIT_CYC  = 6250
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pg_sync,
  output phase_t phase,
  output logic   start_evt,
  output logic   pg_seen
);
  localparam int unsigned CW = cnt_bits(STARTUP_CYC, PDEXIT_CYC);
  localparam logic [CW-1:0] START_LAST = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(PDEXIT_CYC - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start_done, exit_done;

  assign start_done = (cnt_q == START_LAST);
  assign exit_done  = (cnt_q == EXIT_LAST);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_WAIT: if (!pg_sync) begin
        ph_d  = PH_START;
        cnt_d = '0;
      end
      PH_START: begin
        if (pg_sync)         ph_d = PH_PD;
        else if (start_done) ph_d = PH_RUN;
        else                 cnt_d = cnt_q + CW'(1);
      end
      PH_RUN: if (pg_sync) ph_d = PH_PD;
      PH_PD: if (!pg_sync) begin
        ph_d  = PH_EXIT;
        cnt_d = '0;
      end
      PH_EXIT: begin
        if (pg_sync)        ph_d = PH_PD;
        else if (exit_done) ph_d = PH_RUN;
        else                cnt_d = cnt_q + CW'(1);
      end
      default: ph_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_WAIT;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase     = ph_q;
  assign start_evt = (ph_q == PH_WAIT) && !pg_sync;
  assign pg_seen   = (ph_q != PH_WAIT);

  // R3
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_START && !pg_sync && !start_done) |=> ph_q == PH_START);

  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PD && pg_sync) |=> ph_q == PH_PD);

  // R2
  wait_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_WAIT) |=> ph_q != PH_WAIT);
endmodule

// File: rtl/clkpu_strap.sv
`timescale 1ns/1ps
module clkpu_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic pg_seen,
  input  logic strap_fsel,
  input  logic strap_tsel,
  input  logic test_pin,
  input  logic reg_test_en,
  input  logic reg_test_type,
  output logic fsel_q,
  output logic test_on,
  output logic test_ref
);
  logic tsel_q, sw_test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q    <= 1'b1;
      tsel_q    <= 1'b0;
      sw_test_q <= 1'b0;
    end else begin
      if (start_evt) begin
        fsel_q <= strap_fsel;
        tsel_q <= strap_tsel;
      end
      if (pg_seen && !tsel_q && reg_test_en) sw_test_q <= 1'b1;
    end
  end

  assign test_on  = tsel_q | sw_test_q;
  assign test_ref = tsel_q ? test_pin : reg_test_type;

  // R2
  fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_seen && !start_evt) |=> $stable(fsel_q));

  // R8
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_on |=> test_on);

  // R7
  sw_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_seen && reg_test_en) |=> test_on);
endmodule

// File: rtl/clkpu_grpmap.sv
`timescale 1ns/1ps
module clkpu_grpmap
  import clkpu_pkg::*;
#(
  parameter int unsigned     NGRP      = 4,
  parameter logic [NGRP-1:0] GRP_DIFF  = 4'b0011,
  parameter logic [NGRP-1:0] GRP_STRAP = 4'b0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              pd_force,
  input  logic              test_on,
  input  logic              test_ref,
  output logic [2*NGRP-1:0] codes
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign codes[2*g +: 2] = group_code(phase, pd_force, GRP_DIFF[g],
                                        GRP_STRAP[g], test_on, test_ref);
    if (GRP_DIFF[g]) begin : g_diff
      // R4
      pd_diff_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_force |-> codes[2*g +: 2] == C_HIZ);
      // R5
      exit_diff_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXIT) |-> codes[2*g +: 2] == C_HIZ);
    end else begin : g_se
      // R4
      pd_se_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_force |-> codes[2*g +: 2] == C_LOW);
      if (GRP_STRAP[g]) begin : g_strap
        // R1
        pre_strap_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (phase == PH_WAIT) |-> codes[2*g +: 2] == C_HIZ);
      end
    end
  end
endmodule

// File: rtl/clkpu_ctrl.sv
`timescale 1ns/1ps
module clkpu_ctrl
  import clkpu_pkg::*;
#(
  parameter int unsigned     NGRP        = 4,
  parameter logic [NGRP-1:0] GRP_DIFF    = 4'b0011,
  parameter logic [NGRP-1:0] GRP_STRAP   = 4'b0100,
  parameter int unsigned     STARTUP_CYC = 45000,
  parameter int unsigned     PDEXIT_CYC  = 6250,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_pd,
  input  logic              strap_fsel,
  input  logic              strap_tsel,
  input  logic              test_pin,
  input  logic              reg_test_en,
  input  logic              reg_test_type,
  output logic [2*NGRP-1:0] grp_codes,
  output logic              fsel_latched
);
  logic   pg_sync, start_evt, pg_seen, pd_force, test_on, test_ref;
  phase_t phase;

  clkpu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pwrgd_pd), .q(pg_sync));

  clkpu_seq #(.STARTUP_CYC(STARTUP_CYC), .PDEXIT_CYC(PDEXIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pg_sync(pg_sync),
    .phase(phase), .start_evt(start_evt), .pg_seen(pg_seen));

  clkpu_strap u_strap (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .pg_seen(pg_seen),
    .strap_fsel(strap_fsel), .strap_tsel(strap_tsel), .test_pin(test_pin),
    .reg_test_en(reg_test_en), .reg_test_type(reg_test_type),
    .fsel_q(fsel_latched), .test_on(test_on), .test_ref(test_ref));

  // Power-down acts straight from the pin once power-good has been seen.
  assign pd_force = pg_seen & pwrgd_pd;

  clkpu_grpmap #(.NGRP(NGRP), .GRP_DIFF(GRP_DIFF), .GRP_STRAP(GRP_STRAP)) u_map (
    .clk(clk), .rst_n(rst_n), .phase(phase), .pd_force(pd_force),
    .test_on(test_on), .test_ref(test_ref), .codes(grp_codes));

  // R9
  idle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && !pwrgd_pd && !test_on) |-> grp_codes == '0);
endmodule

// File: tb/clkpu_ctrl_test.sv
`timescale 1ns/1ps
module clkpu_ctrl_test;
  localparam int S = 20;
  localparam int P = 10;
  localparam logic [1:0] RUN = 2'd0, HIZ = 2'd1, LOW = 2'd2, REF = 2'd3;
  localparam logic [7:0] PRE  = {LOW, HIZ, HIZ, HIZ};
  localparam logic [7:0] PDC  = {LOW, LOW, HIZ, HIZ};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrgd_pd = 1'b1;
  logic strap_fsel = 1'b1, strap_tsel = 1'b0, test_pin = 1'b0;
  logic reg_test_en = 1'b0, reg_test_type = 1'b0;
  logic [7:0] grp_codes;
  logic fsel_latched;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkpu_ctrl #(.STARTUP_CYC(S), .PDEXIT_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .pwrgd_pd(pwrgd_pd), .strap_fsel(strap_fsel),
    .strap_tsel(strap_tsel), .test_pin(test_pin), .reg_test_en(reg_test_en),
    .reg_test_type(reg_test_type), .grp_codes(grp_codes), .fsel_latched(fsel_latched));

  function automatic logic [7:0] allc(input logic [1:0] l); return {l, l, l, l}; endfunction
  function automatic logic [7:0] exitc(input logic [1:0] l); return {l, l, HIZ, HIZ}; endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pwrgd_pd = 1'b1; reg_test_en = 1'b0; reg_test_type = 1'b0;
    test_pin = 1'b0; strap_fsel = 1'b1; strap_tsel = 1'b0;
    #1 chk("R1 codes in reset", grp_codes, PRE);
    chk("R2 fsel reads 1 in reset", {7'd0, fsel_latched}, 8'd1);
    edges(2); rst_n = 1'b1;
    edges(4);
    chk("R1 codes before power-good", grp_codes, PRE);
  endtask

  task automatic power_up(input logic fs, input logic ts, input logic [1:0] lexp);
    strap_fsel = fs; strap_tsel = ts; pwrgd_pd = 1'b0;
    edges(2);
    chk("R1 codes two edges after power-good", grp_codes, PRE);
    chk("R2 fsel not yet sampled", {7'd0, fsel_latched}, 8'd1);
    edges(1);
    chk("R2 fsel sampled", {7'd0, fsel_latched}, {7'd0, fs});
    chk("R3 startup codes", grp_codes, PDC);
    edges(S - 1);
    chk("R3 not running one edge early", grp_codes, PDC);
    edges(1);
    chk("R3 running on time", grp_codes, allc(lexp));
  endtask

  task automatic pd_cycle(input logic [1:0] lexp);
    pwrgd_pd = 1'b1;
    #1 chk("R4 immediate power-down codes", grp_codes, PDC);
    edges(4);
    chk("R4 power-down held", grp_codes, PDC);
    pwrgd_pd = 1'b0;
    edges(2);
    chk("R5 single-ended still low", grp_codes, PDC);
    edges(1);
    chk("R5 single-ended resume", grp_codes, exitc(lexp));
    edges(P - 1);
    chk("R5 differential still off one edge early", grp_codes, exitc(lexp));
    edges(1);
    chk("R5 differential resume", grp_codes, allc(lexp));
  endtask

  task automatic scen_normal();
    do_reset();
    power_up(1'b0, 1'b0, RUN);
    strap_fsel = 1'b1;
    edges(3);
    chk("R2 strap change ignored", {7'd0, fsel_latched}, 8'd0);
    test_pin = 1'b1; edges(2);
    chk("R9 normal run ignores test pin", grp_codes, allc(RUN));
    test_pin = 1'b0;
    pd_cycle(RUN);
    chk("R2 fsel held across power-down", {7'd0, fsel_latched}, 8'd0);
  endtask

  task automatic scen_sw_test();
    do_reset();
    power_up(1'b1, 1'b0, RUN);
    chk("R2 fsel sampled as 1", {7'd0, fsel_latched}, 8'd1);
    reg_test_en = 1'b1;
    edges(1);
    chk("R7 register test Hi-Z", grp_codes, allc(HIZ));
    test_pin = 1'b1;
    #1 chk("R7 test pin ignored", grp_codes, allc(HIZ));
    reg_test_type = 1'b1;
    #1 chk("R7 register type divided ref", grp_codes, allc(REF));
    reg_test_en = 1'b0;
    edges(3);
    chk("R8 stays after bit cleared", grp_codes, allc(REF));
    pd_cycle(REF);
    test_pin = 1'b0;
    do_reset();
    power_up(1'b1, 1'b0, RUN);
    chk("R8 reset clears test mode", grp_codes, allc(RUN));
  endtask

  task automatic scen_hw_test();
    do_reset();
    reg_test_type = 1'b1;
    power_up(1'b1, 1'b1, HIZ);
    test_pin = 1'b1;
    #1 chk("R6 pin selects divided ref", grp_codes, allc(REF));
    reg_test_type = 1'b0;
    #1 chk("R6 register type ignored", grp_codes, allc(REF));
    test_pin = 1'b0;
    #1 chk("R6 pin selects Hi-Z", grp_codes, allc(HIZ));
    reg_test_en = 1'b1; reg_test_type = 1'b1;
    edges(2);
    chk("R6 register bits ignored", grp_codes, allc(HIZ));
    pd_cycle(HIZ);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    scen_normal();
    scen_sw_test();
    scen_hw_test();
    report();
  end

  initial begin
    #(8 * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end
endmodule